// File: doc/BRIEF.md
# Inter-core doorbell controller

This block lets any core in a small cluster ring a doorbell on any other core (or on itself) and hand over a 16-bit message with the interrupt. Each core owns one 32-bit control word and one 32-bit status word, both reached through a single 32-bit register port. A core sends a doorbell by writing its own control word with the generate flag set, a destination index and a payload. The addressed core then sees its status word loaded with a pending flag, the sender's index and the payload, and its interrupt line rises. The receiver takes the doorbell by writing its own control word with the acknowledge flag set. That clears its pending flag and drops its line, and leaves the sender index and payload in place to be read.

The address space holds four 8-byte slots. Address bits 4:3 pick the core and bit 2 picks the word: 0 is control, 1 is status. The parameter `NUM_CORES` (1 to 4, default 1) sets how many slots are populated. The request side is a valid/ready channel whose ready is held high, so the block never applies back-pressure and every valid beat is taken on the edge where it is presented. A read beat returns its data on the response channel one cycle later. The response channel has no ready, so the requester must be able to take that beat.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset every control and status word reads as zero, every interrupt line is low and the response valid is low.
- R2: `req_ready` is always 1. A read beat accepted on edge N gives `rsp_valid` = 1 with the addressed word on `rsp_data` for exactly the cycle after edge N. A write beat never raises `rsp_valid`. Address bit 2 selects control (0) or status (1), and bits 4:3 select the core.
- R3: A write to a populated core's control word stores all 32 bits, and a later read returns them.
- R4: A control write with bit 30 (generate) set and a destination in bits 29:16 below `NUM_CORES` sets the destination's status to bit 31 = 0, bit 30 = 1, bits 29:16 = the writing core's index, bits 15:0 = the written bits 15:0. The destination's interrupt line is high from the next cycle.
- R5: A control write with bit 31 (acknowledge) set clears bit 30 of the writer's own status word and lowers the writer's interrupt line. All other status bits and all other cores are left unchanged.
- R6: When generate and acknowledge are set in one write, the generate is applied first. A core that signals itself this way ends with its new sender index and payload, with pending clear and its line low.
- R7: A generate whose destination is at or above `NUM_CORES` changes no status word and no interrupt line. The control word is still stored.
- R8: Writes to a status word change no register and no interrupt line.
- R9: Accesses to a core index at or above `NUM_CORES` are ignored: writes change nothing and reads return zero.
- R10: A generate to a core whose doorbell is already pending replaces the sender index and payload, and pending stays set.
- R11: A control write with neither bit 31 nor bit 30 set leaves every status word and interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request accepted; held at 1 |
| req_write | input | 1 | 1 = write beat, 0 = read beat |
| req_addr | input | 5 | Byte address: bits 4:3 core, bit 2 word select |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read beat |
| rsp_data | output | 32 | Read data |
| irq_o | output | NUM_CORES | Doorbell interrupt line, one per core |

## Verification
The bench builds the block with `NUM_CORES` = 3. With that value the fourth address slot can be decoded but is not populated, so both out-of-range cases are exercised: a foreign core index (R9) and a destination index that is too high (R7, using 3 and 20). It sweeps every writer slot against every destination, with and without a simultaneous acknowledge. After each write it reads back all status words and compares every interrupt line with values built arithmetically from the field layout. Self-signalling, overwrite of a pending doorbell, status-word writes and neutral control writes are each driven separately.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_CORES = 4;
  localparam int BIT_ACK   = 31;
  localparam int BIT_GEN   = 30;
  localparam int BIT_PEND  = 30;
  localparam int IDX_LSB   = 16;
  localparam int IDX_FW    = 14;
  localparam int MSG_W     = 16;

  function automatic logic [WORD_W-1:0] pack_status(input logic [IDX_FW-1:0] src,
                                                    input logic [MSG_W-1:0]  msg);
    pack_status = {1'b0, 1'b1, src, msg};
  endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int IDX_W     = 2,
  localparam int ADDR_W   = IDX_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic [IDX_W-1:0]     core_idx,
  output logic                 core_ok,
  output logic                 rd_go,
  output logic                 rd_status,
  output logic [NUM_CORES-1:0] ctrl_sel,
  output logic [NUM_CORES-1:0] gen_sel,
  output logic [NUM_CORES-1:0] ack_sel
);
  logic              ctrl_we;
  logic [IDX_FW-1:0] dst;
  logic              dst_ok;

  assign core_idx  = req_addr[ADDR_W-1:3];
  assign rd_status = req_addr[2];
  assign core_ok   = 32'(core_idx) < NUM_CORES;
  assign rd_go     = req_valid && !req_write;
  assign ctrl_we   = req_valid && req_write && !req_addr[2] && core_ok;
  assign dst       = req_wdata[IDX_LSB +: IDX_FW];
  assign dst_ok    = 32'(dst) < NUM_CORES;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_sel
    assign ctrl_sel[i] = ctrl_we && (core_idx == IDX_W'(i));
    assign ack_sel[i]  = ctrl_sel[i] && req_wdata[BIT_ACK];
    assign gen_sel[i]  = ctrl_we && req_wdata[BIT_GEN] && dst_ok && (dst == IDX_FW'(i));
  end

  // R9: a foreign core index selects no slot
  a_r9_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !core_ok) |-> (ctrl_sel == '0 && gen_sel == '0));
  // R7: an out-of-range destination raises no doorbell
  a_r7_dst_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !dst_ok) |-> (gen_sel == '0));
  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gen_sel) && $onehot0(ctrl_sel));
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              gen_hit,
  input  logic              ack_hit,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] stat_q,
  output logic              irq_q
);
  logic [WORD_W-1:0] stat_d;
  logic              irq_d;

  always_comb begin
    stat_d = stat_q;
    irq_d  = irq_q;
    if (gen_hit) begin
      stat_d = pack_status(IDX_FW'(src_idx), wdata[MSG_W-1:0]);
      irq_d  = 1'b1;
    end
    if (ack_hit) begin
      stat_d[BIT_PEND] = 1'b0;
      irq_d            = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata)));
  a_r4_gen_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_hit && !ack_hit) |=> (irq_q && stat_q[BIT_PEND]));
  a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> (!irq_q && !stat_q[BIT_PEND]));
  // R6: generate then acknowledge keeps the new message
  a_r6_both_order: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_hit && ack_hit) |=> (stat_q[MSG_W-1:0] == $past(wdata[MSG_W-1:0])));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_hit && !ack_hit) |=> ($stable(stat_q) && $stable(irq_q)));
  a_r4_line_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == stat_q[BIT_PEND]);
endmodule

// File: rtl/ipi_rd_port.sv
module ipi_rd_port
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int IDX_W     = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_go,
  input  logic                              rd_status,
  input  logic [IDX_W-1:0]                  core_idx,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  ctrl_all,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]  stat_all,
  output logic                              rsp_valid,
  output logic [WORD_W-1:0]                 rsp_data
);
  logic [WORD_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core_idx == IDX_W'(i)) pick = rd_status ? stat_all[i] : ctrl_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_data <= pick;
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rsp_valid);
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  localparam int IDX_W    = $clog2(MAX_CORES),
  localparam int ADDR_W   = IDX_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [WORD_W-1:0]    rsp_data,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [IDX_W-1:0]                 core_idx;
  logic                             core_ok;
  logic                             rd_go;
  logic                             rd_status;
  logic [NUM_CORES-1:0]             ctrl_sel;
  logic [NUM_CORES-1:0]             gen_sel;
  logic [NUM_CORES-1:0]             ack_sel;
  logic [NUM_CORES-1:0][WORD_W-1:0] ctrl_all;
  logic [NUM_CORES-1:0][WORD_W-1:0] stat_all;

  assign req_ready = 1'b1;

  ipi_addr_dec #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .core_idx(core_idx), .core_ok(core_ok),
    .rd_go(rd_go), .rd_status(rd_status),
    .ctrl_sel(ctrl_sel), .gen_sel(gen_sel), .ack_sel(ack_sel)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    ipi_slot #(.IDX_W(IDX_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_sel[i]), .gen_hit(gen_sel[i]), .ack_hit(ack_sel[i]),
      .src_idx(core_idx), .wdata(req_wdata),
      .ctrl_q(ctrl_all[i]), .stat_q(stat_all[i]), .irq_q(irq_o[i])
    );
  end

  ipi_rd_port #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_go(rd_go), .rd_status(rd_status), .core_idx(core_idx),
    .ctrl_all(ctrl_all), .stat_all(stat_all),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  a_r8_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[2]) |=> ($stable(irq_o) && $stable(stat_all)
                                                 && $stable(ctrl_all)));
  a_r9_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !core_ok) |=> ($stable(irq_o) && $stable(stat_all)));
  a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

// File: tb/tb_ipi_doorbell.sv
module tb_ipi_doorbell;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [N-1:0] irq_o;

  int n_total = 0;
  int n_fail  = 0;
  logic [31:0] m_ctrl [4];
  logic [31:0] m_stat [4];

  always #2 clk = ~clk;

  ipi_doorbell #(.NUM_CORES(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_stat[i][30];
    return v;
  endfunction

  // Expected effect of a write, built from the register description
  task automatic model_wr(input logic [4:0] a, input logic [31:0] d);
    int s;
    int dst;
    s = int'(a[4:3]);
    dst = int'(d[29:16]);
    if (s < N && !a[2]) begin
      m_ctrl[s] = d;
      if (d[30] && dst < N) m_stat[dst] = {2'b01, 14'(s), d[15:0]};
      if (d[31]) m_stat[s][30] = 1'b0;
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data; v = rsp_valid;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    logic v;
    chk(req, 32'(irq_o), 32'(exp_irq()));
    for (int i = 0; i < 4; i++) begin
      bus_rd(5'(i * 8 + 4), d, v);
      chk(req, d, (i < N) ? m_stat[i] : 32'h0);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    for (int i = 0; i < 4; i++) begin m_ctrl[i] = '0; m_stat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", 32'(irq_o), 32'h0);
    chk("R1", 32'(rsp_valid), 32'h0);
    for (int i = 0; i < 8; i++) begin
      bus_rd(5'(i * 4), d, v);
      chk("R1", d, 32'h0);
    end

    // R2 handshake and response timing
    chk("R2", 32'(req_ready), 32'h1);
    bus_rd(5'h00, d, v);
    chk("R2", 32'(v), 32'h1);
    @(negedge clk);
    chk("R2", 32'(rsp_valid), 32'h0);
    bus_wr(5'h08, 32'h0000_00A5);
    chk("R2", 32'(rsp_valid), 32'h0);

    // R3 full-word control storage
    bus_wr(5'h10, 32'h3AC5_5A3C);
    bus_rd(5'h10, d, v);
    chk("R3", d, m_ctrl[2]);
    chk("R11", 32'(irq_o), 32'h0);

    // Sweep: every writer slot x destination, generate with and without ack
    for (int s = 0; s < 4; s++) begin
      for (int di = 0; di < 5; di++) begin
        for (int m = 0; m < 2; m++) begin
          int dst;
          string tag;
          logic [31:0] w;
          dst = (di < 4) ? di : 20;
          tag = (s >= N) ? "R9" : (dst >= N) ? "R7" : (m == 1) ? "R6" : "R4";
          w = {1'(m), 1'b1, 14'(dst), 16'(s * 16'h1111 ^ dst * 16'h0707 ^ m)};
          bus_wr(5'(s * 8), w);
          check_all(tag);
          bus_rd(5'(s * 8), d, v);
          chk((s >= N) ? "R9" : "R3", d, (s < N) ? m_ctrl[s] : 32'h0);
          for (int c = 0; c < N; c++) bus_wr(5'(c * 8), 32'h8000_0000);
          check_all("R5");
        end
      end
    end

    // R10 overwrite of a pending doorbell
    bus_wr(5'h00, {2'b01, 14'd1, 16'h1357});
    bus_wr(5'h10, {2'b01, 14'd1, 16'h2468});
    check_all("R10");

    // R5 ack keeps sender and payload, leaves other cores alone
    bus_wr(5'h00, {2'b01, 14'd2, 16'hBEEF});
    bus_wr(5'h08, 32'h8000_0000);
    check_all("R5");
    chk("R5", m_stat[1], {2'b00, 14'd2, 16'h2468});

    // R8 status writes ignored
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_wr(5'h0C, 32'hC000_0000);
    check_all("R8");
    bus_rd(5'h10, d, v);
    chk("R8", d, m_ctrl[2]);

    // R11 neutral control write
    bus_wr(5'h10, 32'h3FFF_1234);
    check_all("R11");

    // R9 foreign slot write then read
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_rd(5'h18, d, v);
    chk("R9", d, 32'h0);
    check_all("R9");

    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end
endmodule